// File: doc/BRIEF.md
# Series Cell Charge/Discharge Protection Controller

This block supervises a stack of three or four series-connected lithium cells. Analog comparators outside the block turn each cell voltage into four flags per cell: above the overcharge limit, below the overcharge release level, below the overdischarge limit, and above the overdischarge release level. The block qualifies these flags over time and drives a charge-inhibit and a discharge-inhibit output. It also drives one bleed enable per cell for cell balancing and reports whether it is in the low-power sleep state.

Each fault must persist for a programmable number of ticks of a shared clock-enable strobe before it is declared. Release has no delay and uses the hysteresis level given by the release flag. An overdischarge puts the block to sleep. In sleep, every detection timer is stopped except the overcharge timers of cells that were overcharged at the moment sleep began. Only a charger-present indication wakes the block.

Top module: `cellguard_top`

## Requirements
- R1: After reset `pwr_down` is 1, and `chg_inhibit`, `dsg_inhibit` and every bit of `bleed_en` are 0.
- R2: While asleep, the block stays asleep until `chg_present` is 1 on a clock edge, and is awake (`pwr_down`=0) from the next cycle. While awake, `chg_present` has no effect.
- R3: A cell's overcharge timer counts `tick_en` pulses while its `ovc_hi` flag stays 1, and returns to zero in any cycle where the flag is 0. Once the count equals `ovc_delay` and the flag is still 1, that cell trips, and `chg_inhibit` is 1 from the next cycle. A delay of 0 trips on the first cycle the flag is seen.
- R4: A tripped cell is cleared one clock after its `ovc_rel_lo` flag is 1. Clearing wins over tripping. `chg_inhibit` is 0 once no cell remains tripped. The band between the two flags (both 0) holds the trip.
- R5: The overdischarge timers behave like the R3 timers, using `ovd_lo`, `ovd_delay` and the output `dsg_inhibit`. They run only while awake.
- R6: A cell's overdischarge trip clears one clock after its `ovd_rel_hi` flag is 1. `dsg_inhibit` is 0 once no cell remains tripped.
- R7: Bit i of `bleed_en` is 1 exactly while cell i holds an overcharge trip. Bit i is 1 only while `chg_inhibit` is 1.
- R8: An overdischarge trip puts the block to sleep on the next cycle. In sleep, the overdischarge timers are held at zero. The overcharge timers run only for cells whose `ovc_hi` was 1 in the cycle of the trip. Asleep from reset, no overcharge timer runs.
- R9: With `four_cell`=0, all flags of the top cell (bit 3) are ignored. `bleed_en[3]` is 0 at once, and any trip the top cell held is cleared on the next edge. With `four_cell`=1, all four cells are monitored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Delay time-base strobe, one tick per cycle high |
| four_cell | input | 1 | 1: four cells monitored, 0: three cells (bit 3 ignored) |
| ovc_delay | input | 16 | Overcharge qualification delay in ticks |
| ovd_delay | input | 16 | Overdischarge qualification delay in ticks |
| ovc_hi | input | 4 | Per cell: voltage above overcharge limit |
| ovc_rel_lo | input | 4 | Per cell: voltage below overcharge release level |
| ovd_lo | input | 4 | Per cell: voltage below overdischarge limit |
| ovd_rel_hi | input | 4 | Per cell: voltage above overdischarge release level |
| chg_present | input | 1 | Charger detected |
| chg_inhibit | output | 1 | Block charging |
| dsg_inhibit | output | 1 | Block discharging |
| bleed_en | output | 4 | Per-cell balancing bleed enable |
| pwr_down | output | 1 | Block is in sleep state |

## Verification
The overcharge and overdischarge paths are driven with short bursts separated by single-cycle gaps and then with sustained faults. This shows whether the timers restart on a drop or only accumulate. Faults on two cells at once, released one at a time, show that the trips are held per cell and not merged into one. A fault raised before sleep and another raised after it shows which timers keep running in sleep. Flags on the top cell in three-cell mode, together with a mode switch while that cell is tripped, show that the cell is masked. The flags move through the hysteresis band, where both flags are 0, to show that release needs the release flag and not merely the loss of the fault flag.

// File: rtl/cellguard_pkg.sv
package cellguard_pkg;
  localparam int CG_CELLS = 4;
  localparam int CG_DLY_W = 16;

  // Cells monitored for a given cell-count select: reduced mode drops the top cell.
  function automatic logic [CG_CELLS-1:0] active_mask(input logic full);
    logic [CG_CELLS-1:0] m;
    m = '1;
    if (!full) m[CG_CELLS-1] = 1'b0;
    return m;
  endfunction

  // Next value of a qualification counter.
  function automatic logic [CG_DLY_W-1:0] qual_next(input logic qual, input logic tick,
                                                    input logic [CG_DLY_W-1:0] cnt,
                                                    input logic [CG_DLY_W-1:0] limit);
    if (!qual) return '0;
    if (tick && cnt < limit) return cnt + 1'b1;
    return cnt;
  endfunction
endpackage

// File: rtl/cg_qual_timer.sv
module cg_qual_timer #(
  parameter int W = cellguard_pkg::CG_DLY_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         qual,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cellguard_pkg::qual_next(qual, tick, cnt, limit);
  end

  assign done = qual && (cnt >= limit);
endmodule

// File: rtl/cg_trip_latch.sv
module cg_trip_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/cg_sleep_ctrl.sv
module cg_sleep_ctrl #(
  parameter int N = cellguard_pkg::CG_CELLS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wake,
  input  logic         od_trip_any,
  input  logic [N-1:0] oc_now,
  output logic         asleep,
  output logic [N-1:0] keep_oc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asleep  <= 1'b1;
      keep_oc <= '0;
    end else if (asleep) begin
      if (wake) begin
        asleep  <= 1'b0;
        keep_oc <= '0;
      end
    end else if (od_trip_any) begin
      asleep  <= 1'b1;
      keep_oc <= oc_now;
    end
  end
endmodule

// File: rtl/cellguard_top.sv
module cellguard_top
  import cellguard_pkg::*;
#(
  parameter int N     = CG_CELLS,
  parameter int DLY_W = CG_DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             four_cell,
  input  logic [DLY_W-1:0] ovc_delay,
  input  logic [DLY_W-1:0] ovd_delay,
  input  logic [N-1:0]     ovc_hi,
  input  logic [N-1:0]     ovc_rel_lo,
  input  logic [N-1:0]     ovd_lo,
  input  logic [N-1:0]     ovd_rel_hi,
  input  logic             chg_present,
  output logic             chg_inhibit,
  output logic             dsg_inhibit,
  output logic [N-1:0]     bleed_en,
  output logic             pwr_down
);
  logic [N-1:0] act;
  logic [N-1:0] keep_oc;
  logic [N-1:0] oc_qual, od_qual;
  logic [N-1:0] oc_done, od_done;
  logic [N-1:0] oc_lat, od_lat;
  logic         asleep;
  logic         ovc_trip_any;
  logic         dsg_trip_any;

  assign act = active_mask(four_cell);

  for (genvar i = 0; i < N; i++) begin : g_cell
    assign oc_qual[i] = ovc_hi[i] && act[i] && (!asleep || keep_oc[i]);
    assign od_qual[i] = ovd_lo[i] && act[i] && !asleep;

    cg_qual_timer #(.W(DLY_W)) u_oc_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .qual(oc_qual[i]),
      .limit(ovc_delay), .done(oc_done[i]));

    cg_qual_timer #(.W(DLY_W)) u_od_tmr (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .qual(od_qual[i]),
      .limit(ovd_delay), .done(od_done[i]));

    cg_trip_latch u_oc_lat (
      .clk(clk), .rst_n(rst_n), .set(oc_done[i]),
      .clr(ovc_rel_lo[i] || !act[i]), .q(oc_lat[i]));

    cg_trip_latch u_od_lat (
      .clk(clk), .rst_n(rst_n), .set(od_done[i]),
      .clr(ovd_rel_hi[i] || !act[i]), .q(od_lat[i]));
  end

  assign ovc_trip_any = |oc_done;
  assign dsg_trip_any = |od_done;

  cg_sleep_ctrl #(.N(N)) u_sleep (
    .clk(clk), .rst_n(rst_n), .wake(chg_present), .od_trip_any(dsg_trip_any),
    .oc_now(ovc_hi & act), .asleep(asleep), .keep_oc(keep_oc));

  assign chg_inhibit = |oc_lat;
  assign dsg_inhibit = |od_lat;
  assign bleed_en    = oc_lat & act;
  assign pwr_down    = asleep;
endmodule

// File: rtl/cellguard_chk.sv
module cellguard_chk #(
  parameter int N = cellguard_pkg::CG_CELLS
) (
  input logic         clk,
  input logic         rst_n,
  input logic         four_cell,
  input logic [N-1:0] ovc_rel_lo,
  input logic [N-1:0] ovd_rel_hi,
  input logic         chg_present,
  input logic         chg_inhibit,
  input logic         dsg_inhibit,
  input logic [N-1:0] bleed_en,
  input logic         pwr_down,
  input logic         oc_trip_any,
  input logic         od_trip_any
);
  assert_pd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down && !chg_present |=> pwr_down);

  assert_pd_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down && chg_present |=> !pwr_down);

  assert_chg_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_inhibit) |-> $past(oc_trip_any));

  assert_chg_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    |(bleed_en & ovc_rel_lo) |=> ((bleed_en & $past(bleed_en & ovc_rel_lo)) == '0));

  assert_dsg_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsg_inhibit) |-> $past(od_trip_any));

  assert_dsg_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dsg_inhibit && (&ovd_rel_hi) |=> !dsg_inhibit);

  assert_bleed_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    |bleed_en |-> chg_inhibit);

  assert_sleep_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    od_trip_any && !pwr_down |=> pwr_down && dsg_inhibit);

  assert_top_cell_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !four_cell && $past(!four_cell) |-> !bleed_en[N-1]);
endmodule

bind cellguard_top cellguard_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .four_cell(four_cell), .ovc_rel_lo(ovc_rel_lo),
  .ovd_rel_hi(ovd_rel_hi), .chg_present(chg_present), .chg_inhibit(chg_inhibit),
  .dsg_inhibit(dsg_inhibit), .bleed_en(bleed_en), .pwr_down(pwr_down),
  .oc_trip_any(ovc_trip_any), .od_trip_any(dsg_trip_any));

// File: tb/cellguard_top_tb.sv
module cellguard_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick_en = 0;
  logic        four_cell = 1;
  logic [15:0] ovc_delay = 16'd5;
  logic [15:0] ovd_delay = 16'd4;
  logic [3:0]  ovc_hi = 4'h0, ovc_rel_lo = 4'hF, ovd_lo = 4'h0, ovd_rel_hi = 4'hF;
  logic        chg_present = 0;
  logic        chg_inhibit, dsg_inhibit, pwr_down;
  logic [3:0]  bleed_en;

  int n_checks = 0, n_fail = 0, cyc = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  cellguard_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .four_cell(four_cell),
    .ovc_delay(ovc_delay), .ovd_delay(ovd_delay), .ovc_hi(ovc_hi),
    .ovc_rel_lo(ovc_rel_lo), .ovd_lo(ovd_lo), .ovd_rel_hi(ovd_rel_hi),
    .chg_present(chg_present), .chg_inhibit(chg_inhibit), .dsg_inhibit(dsg_inhibit),
    .bleed_en(bleed_en), .pwr_down(pwr_down));

  // Behavioural reference model
  int m_oc[4], m_od[4];
  bit m_ocl[4], m_odl[4], m_keep[4];
  bit m_sleep = 1;

  always @(posedge clk) begin
    bit ocd[4], odd[4], any_od, used;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_oc[i] = 0; m_od[i] = 0; m_ocl[i] = 0; m_odl[i] = 0; m_keep[i] = 0;
      end
      m_sleep = 1;
    end else begin
      any_od = 0;
      for (int i = 0; i < 4; i++) begin
        used = (i < 3) || four_cell;
        // overcharge path
        if (ovc_hi[i] && used && (!m_sleep || m_keep[i])) begin
          ocd[i] = (m_oc[i] >= int'(ovc_delay));
          if (tick_en && m_oc[i] < int'(ovc_delay)) m_oc[i]++;
        end else begin
          ocd[i] = 0; m_oc[i] = 0;
        end
        // overdischarge path
        if (ovd_lo[i] && used && !m_sleep) begin
          odd[i] = (m_od[i] >= int'(ovd_delay));
          if (tick_en && m_od[i] < int'(ovd_delay)) m_od[i]++;
        end else begin
          odd[i] = 0; m_od[i] = 0;
        end
        if (odd[i]) any_od = 1;
        if (ovc_rel_lo[i] || !used) m_ocl[i] = 0; else if (ocd[i]) m_ocl[i] = 1;
        if (ovd_rel_hi[i] || !used) m_odl[i] = 0; else if (odd[i]) m_odl[i] = 1;
      end
      if (m_sleep) begin
        if (chg_present) begin
          m_sleep = 0;
          for (int i = 0; i < 4; i++) m_keep[i] = 0;
        end
      end else if (any_od) begin
        m_sleep = 1;
        for (int i = 0; i < 4; i++) m_keep[i] = ovc_hi[i] && ((i < 3) || four_cell);
      end
    end
  end

  task automatic check(string tag, string what, int actual, int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    int eb, ec, ed;
    cyc++;
    if (rst_n) begin
      eb = 0; ec = 0; ed = 0;
      for (int i = 0; i < 4; i++) begin
        if (m_ocl[i] && ((i < 3) || four_cell)) eb |= (1 << i);
        if (m_ocl[i]) ec = 1;
        if (m_odl[i]) ed = 1;
      end
      check(phase, "model chg_inhibit", chg_inhibit, ec);
      check(phase, "model dsg_inhibit", dsg_inhibit, ed);
      check(phase, "model bleed_en", bleed_en, eb);
      check(phase, "model pwr_down", pwr_down, m_sleep);
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      tick_en = (cyc % 2 == 0);
    end
  endtask

  // Cell i into overcharge (o=1) / release (o=0) / hysteresis band (o=2)
  task automatic set_oc(int i, int o);
    ovc_hi[i]     = (o == 1);
    ovc_rel_lo[i] = (o == 0);
  endtask
  task automatic set_od(int i, int o);
    ovd_lo[i]     = (o == 1);
    ovd_rel_hi[i] = (o == 0);
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_n = 1;
        step(1);
        phase = "R1";
        check("R1", "pwr_down", pwr_down, 1);
        check("R1", "chg_inhibit", chg_inhibit, 0);
        check("R1", "dsg_inhibit", dsg_inhibit, 0);
        check("R1", "bleed_en", bleed_en, 0);

        phase = "R8";                       // asleep from reset: no timer runs
        set_oc(0, 1); step(30);
        check("R8", "chg_inhibit asleep from reset", chg_inhibit, 0);
        set_oc(0, 0); step(2);

        phase = "R2";
        chg_present = 1; step(1); chg_present = 0; step(1);
        check("R2", "pwr_down after charger", pwr_down, 0);
        chg_present = 1; step(3); chg_present = 0; step(1);
        check("R2", "pwr_down stays awake", pwr_down, 0);

        phase = "R3";                       // bursts shorter than the delay
        set_oc(1, 1); step(6); set_oc(1, 2); step(1);
        set_oc(1, 1); step(6); set_oc(1, 2); step(1);
        check("R3", "chg_inhibit after bursts", chg_inhibit, 0);
        set_oc(1, 1); step(20);
        check("R3", "chg_inhibit sustained", chg_inhibit, 1);
        check("R7", "bleed_en single cell", bleed_en, 4'b0010);

        phase = "R4";
        set_oc(1, 2); step(5);
        check("R4", "chg_inhibit in hysteresis band", chg_inhibit, 1);
        set_oc(1, 0); step(1);
        check("R4", "chg_inhibit released", chg_inhibit, 0);

        phase = "R7";
        set_oc(0, 1); set_oc(2, 1); step(20);
        check("R7", "bleed_en two cells", bleed_en, 4'b0101);
        set_oc(0, 0); step(1);
        check("R7", "bleed_en one released", bleed_en, 4'b0100);
        check("R4", "chg_inhibit with one left", chg_inhibit, 1);
        set_oc(2, 0); step(1);
        check("R4", "chg_inhibit all released", chg_inhibit, 0);

        ovc_delay = 16'd0;                  // zero delay trips at once
        set_oc(3, 1); step(1); step(1);
        check("R3", "zero delay trip", chg_inhibit, 1);
        set_oc(3, 0); step(1); ovc_delay = 16'd5;

        phase = "R5";
        set_od(2, 1); step(6); set_od(2, 2); step(1);
        set_od(2, 1); step(6); set_od(2, 0); step(1);
        check("R5", "dsg_inhibit after bursts", dsg_inhibit, 0);
        check("R5", "awake after bursts", pwr_down, 0);

        phase = "R9";
        four_cell = 0;
        set_oc(3, 1); set_od(3, 1); step(25);
        check("R9", "chg_inhibit top cell ignored", chg_inhibit, 0);
        check("R9", "dsg_inhibit top cell ignored", dsg_inhibit, 0);
        check("R9", "pwr_down top cell ignored", pwr_down, 0);
        set_od(3, 0); four_cell = 1; step(20);
        check("R9", "bleed_en top cell four-cell mode", bleed_en, 4'b1000);
        four_cell = 0; step(1);
        check("R9", "bleed_en top cell masked", bleed_en, 0);
        check("R9", "chg_inhibit top trip cleared", chg_inhibit, 0);
        set_oc(3, 0); four_cell = 1; step(2);

        phase = "R8";
        set_od(2, 1); step(6);
        set_oc(0, 1); step(6);
        check("R8", "pwr_down after overdischarge", pwr_down, 1);
        check("R6", "dsg_inhibit set", dsg_inhibit, 1);
        check("R8", "chg_inhibit not yet", chg_inhibit, 0);
        set_oc(1, 1); step(20);
        check("R8", "kept cell timer ran", chg_inhibit, 1);
        check("R8", "late cell timer stopped", bleed_en, 4'b0001);

        phase = "R6";
        set_od(2, 0); step(1);
        check("R6", "dsg_inhibit released", dsg_inhibit, 0);
        check("R2", "still asleep without charger", pwr_down, 1);
        set_oc(0, 0); set_oc(1, 0); step(2);
        chg_present = 1; step(1); chg_present = 0; step(1);
        check("R2", "wake by charger", pwr_down, 0);
        set_od(1, 1); step(20);
        check("R5", "dsg_inhibit sustained", dsg_inhibit, 1);
        set_od(1, 0); step(1);
        check("R6", "dsg_inhibit released awake", dsg_inhibit, 0);
        step(4);
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule